// File: doc/BRIEF.md
# Serial Channel Status Flag Unit

This block holds the status of one serial communication channel. A transmit/receive engine sends it single-cycle event strobes for transfer start, transfer end, a load of the shift register from the data buffer, and a store of received data into the buffer. The engine also sends framing, parity and generic receive-error strobes. A host register interface sends data-buffer write and read strobes, stop and suspend requests, the transmit-enable and receive-enable mode bits, and one clear strobe for each error flag.

From these events the unit keeps five flags: transfer-in-progress, buffer-holds-valid-data, framing error, parity error and overrun. It presents them as a 16-bit read-only status word and as an 8-bit view of that word's low byte. Every flag is a register clocked by one clock, so the status outputs have no combinational path from any input. Reading the status word has no side effects.

Top module: `chan_status_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first event, status_word reads 0x0000 and status_byte reads 0x00.
- R2: status_word bit 6 is transfer-in-progress, bit 5 is buffer-valid, bit 2 is framing error, bit 1 is parity error and bit 0 is overrun. All other bits always read 0.
- R3: eng_start sets transfer-in-progress and eng_end clears it. When both arrive in the same cycle, the flag is set.
- R4: host_stop or host_suspend clears transfer-in-progress and buffer-valid. This takes priority over every set event in the same cycle. Neither request changes the error flags.
- R5: host_wr sets buffer-valid when mode_tx_en is 1. When mode_tx_en is 0 and the buffer is empty, host_wr leaves the word unchanged.
- R6: eng_rx_store sets buffer-valid when mode_rx_en is 1, and has no effect when mode_rx_en is 0. host_rd clears buffer-valid when mode_rx_en is 1, and has no effect when mode_rx_en is 0.
- R7: A reception error (err_frame, err_parity or err_rx) sets buffer-valid in any mode. err_frame also sets the framing flag, and err_parity also sets the parity flag.
- R8: eng_shift_load clears buffer-valid when mode_tx_en is 1. Any buffer-valid set event in the same cycle wins over any clear event.
- R9: host_wr while buffer-valid is already 1 sets the overrun flag. This holds even when a stop or suspend request clears buffer-valid in the same cycle.
- R10: Each error flag stays set until its own clear strobe (clr_frame, clr_parity, clr_overrun). A set and a clear of the same error flag in one cycle leaves the flag set.
- R11: status_byte always equals status_word[7:0].
- R12: Each flag change becomes visible on the outputs at the first rising clock edge after the strobe is sampled, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_start | input | 1 | Engine: transfer started |
| eng_end | input | 1 | Engine: transfer finished |
| eng_shift_load | input | 1 | Engine: buffer moved into shift register |
| eng_rx_store | input | 1 | Engine: received data stored in buffer |
| err_frame | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| err_rx | input | 1 | Other reception error strobe |
| host_wr | input | 1 | Host wrote the data buffer |
| host_rd | input | 1 | Host finished reading the data buffer |
| host_stop | input | 1 | Host stop request |
| host_suspend | input | 1 | Host suspend request |
| mode_tx_en | input | 1 | Transmit enabled |
| mode_rx_en | input | 1 | Receive enabled |
| clr_frame | input | 1 | Clear framing error flag |
| clr_parity | input | 1 | Clear parity error flag |
| clr_overrun | input | 1 | Clear overrun flag |
| status_word | output | 16 | Status word |
| status_byte | output | 8 | Low byte of status word |

## Verification
The hardest case to reach is a cycle where several events act on one flag at once. Examples are a host write into a full buffer during a suspend request, a receive store together with a host read, and a stop request that arrives with a start and a receive store. The stimulus table reaches these cases by first moving the flags into the needed state with single events. It then applies the combined strobe vector in one cycle, so that both the priority order and the overrun side effect can be seen in the next status word.

// File: rtl/chst_pkg.sv
package chst_pkg;
  localparam int STATUS_W  = 16;
  localparam int VIEW_W    = 8;
  localparam int NUM_ERR   = 3;
  localparam int BUSY_BIT  = 6;
  localparam int BUF_BIT   = 5;
  // error flag index equals its bit position in the status word
  localparam int OVR_IDX   = 0;
  localparam int PAR_IDX   = 1;
  localparam int FRM_IDX   = 2;

  // force_clr beats set, set beats clr
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr, input logic force_clr);
    if (force_clr)  return 1'b0;
    else if (set)   return 1'b1;
    else if (clr)   return 1'b0;
    else            return cur;
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(input logic busy,
      input logic bufv, input logic [NUM_ERR-1:0] errs);
    logic [STATUS_W-1:0] w;
    w = '0;
    w[BUSY_BIT] = busy;
    w[BUF_BIT]  = bufv;
    w[NUM_ERR-1:0] = errs;
    return w;
  endfunction
endpackage

// File: rtl/chst_busy_flag.sv
module chst_busy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic end_evt,
  input  logic halt_evt,
  output logic busy_q
);
  import chst_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= flag_next(busy_q, start_evt, end_evt, halt_evt);
  end
endmodule

// File: rtl/chst_buffer_flag.sv
module chst_buffer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_rd,
  input  logic rx_store,
  input  logic shift_load,
  input  logic rx_err_evt,
  input  logic tx_en,
  input  logic rx_en,
  input  logic halt_evt,
  output logic bufv_q,
  output logic overrun_evt
);
  import chst_pkg::*;

  logic set_evt;
  logic clr_evt;

  assign set_evt     = (host_wr & tx_en) | (rx_store & rx_en) | rx_err_evt;
  assign clr_evt     = (shift_load & tx_en) | (host_rd & rx_en);
  assign overrun_evt = host_wr & bufv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bufv_q <= 1'b0;
    else        bufv_q <= flag_next(bufv_q, set_evt, clr_evt, halt_evt);
  end
endmodule

// File: rtl/chst_error_bank.sv
module chst_error_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_evt,
  output logic [N-1:0] err_q
);
  import chst_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= flag_next(err_q[i], set_evt[i], clr_evt[i], 1'b0);
    end
  end
endmodule

// File: rtl/chan_status_unit.sv
module chan_status_unit #(
  parameter int STATUS_W = chst_pkg::STATUS_W,
  parameter int VIEW_W   = chst_pkg::VIEW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eng_start,
  input  logic                eng_end,
  input  logic                eng_shift_load,
  input  logic                eng_rx_store,
  input  logic                err_frame,
  input  logic                err_parity,
  input  logic                err_rx,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic                host_stop,
  input  logic                host_suspend,
  input  logic                mode_tx_en,
  input  logic                mode_rx_en,
  input  logic                clr_frame,
  input  logic                clr_parity,
  input  logic                clr_overrun,
  output logic [STATUS_W-1:0] status_word,
  output logic [VIEW_W-1:0]   status_byte
);
  import chst_pkg::*;

  // named internal events, visible to the bound checker
  logic               halt_evt;
  logic               rx_err_evt;
  logic               overrun_evt;
  logic               busy_q;
  logic               bufv_q;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_clr;
  logic [NUM_ERR-1:0] err_q;
  logic [chst_pkg::STATUS_W-1:0] packed_w;

  assign halt_evt   = host_stop | host_suspend;
  assign rx_err_evt = err_frame | err_parity | err_rx;

  chst_busy_flag u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (eng_start),
    .end_evt   (eng_end),
    .halt_evt  (halt_evt),
    .busy_q    (busy_q)
  );

  chst_buffer_flag u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .rx_store    (eng_rx_store),
    .shift_load  (eng_shift_load),
    .rx_err_evt  (rx_err_evt),
    .tx_en       (mode_tx_en),
    .rx_en       (mode_rx_en),
    .halt_evt    (halt_evt),
    .bufv_q      (bufv_q),
    .overrun_evt (overrun_evt)
  );

  always_comb begin
    err_set          = '0;
    err_clr          = '0;
    err_set[OVR_IDX] = overrun_evt;
    err_set[PAR_IDX] = err_parity;
    err_set[FRM_IDX] = err_frame;
    err_clr[OVR_IDX] = clr_overrun;
    err_clr[PAR_IDX] = clr_parity;
    err_clr[FRM_IDX] = clr_frame;
  end

  chst_error_bank #(.N(NUM_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (err_set),
    .clr_evt (err_clr),
    .err_q   (err_q)
  );

  // all sources are flops: the word is a registered output
  assign packed_w    = pack_status(busy_q, bufv_q, err_q);
  assign status_word = STATUS_W'(packed_w);
  assign status_byte = status_word[VIEW_W-1:0];
endmodule

// File: rtl/chst_checker.sv
module chst_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_start,
  input logic        eng_rx_store,
  input logic        mode_rx_en,
  input logic        host_wr,
  input logic        halt_evt,
  input logic        rx_err_evt,
  input logic        clr_frame,
  input logic        err_frame,
  input logic [15:0] status_word
);
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> (!status_word[6] && !status_word[5])); // R4
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !halt_evt) |=> status_word[6]); // R3
  AST_FULL_WRITE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && status_word[5]) |=> status_word[0]); // R9
  AST_RXERR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_evt && !halt_evt) |=> status_word[5]); // R7
  AST_RXSTORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_store && mode_rx_en && !halt_evt) |=> status_word[5]); // R6
  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[2] && !clr_frame) |=> status_word[2]); // R10
  AST_FRAME_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> status_word[2]); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 16'hFF98) == 16'h0000); // R2
endmodule

bind chan_status_unit chst_checker i_chst_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_start    (eng_start),
  .eng_rx_store (eng_rx_store),
  .mode_rx_en   (mode_rx_en),
  .host_wr      (host_wr),
  .halt_evt     (halt_evt),
  .rx_err_evt   (rx_err_evt),
  .clr_frame    (clr_frame),
  .err_frame    (err_frame),
  .status_word  (status_word)
);

// File: tb/test_chan_status_unit.sv
module test_chan_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] stim = '0;
  logic [15:0] status_word;
  logic [7:0]  status_byte;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // stimulus bit positions
  localparam logic [15:0] S_START = 16'h0001, S_END   = 16'h0002,
                          S_SHIFT = 16'h0004, S_RXS   = 16'h0008,
                          S_EFRM  = 16'h0010, S_EPAR  = 16'h0020,
                          S_ERX   = 16'h0040, S_HWR   = 16'h0080,
                          S_HRD   = 16'h0100, S_STOP  = 16'h0200,
                          S_SUSP  = 16'h0400, S_TX    = 16'h0800,
                          S_RX    = 16'h1000, S_CFRM  = 16'h2000,
                          S_CPAR  = 16'h4000, S_COVR  = 16'h8000;

  chan_status_unit i_chan_status_unit (
    .clk(clk), .rst_n(rst_n),
    .eng_start(stim[0]), .eng_end(stim[1]), .eng_shift_load(stim[2]),
    .eng_rx_store(stim[3]), .err_frame(stim[4]), .err_parity(stim[5]),
    .err_rx(stim[6]), .host_wr(stim[7]), .host_rd(stim[8]),
    .host_stop(stim[9]), .host_suspend(stim[10]), .mode_tx_en(stim[11]),
    .mode_rx_en(stim[12]), .clr_frame(stim[13]), .clr_parity(stim[14]),
    .clr_overrun(stim[15]),
    .status_word(status_word), .status_byte(status_byte)
  );

  // {stimulus, expected status word after the edge}
  localparam int NV = 29;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000,                   16'h0000}, // R1 idle
    {S_START,                    16'h0040}, // R3
    {S_END,                      16'h0000}, // R3
    {S_START|S_END,              16'h0040}, // R3 set wins
    {S_STOP,                     16'h0000}, // R4
    {S_HWR,                      16'h0000}, // R5 tx disabled
    {S_HWR|S_TX,                 16'h0020}, // R5
    {S_SHIFT|S_TX,               16'h0000}, // R8
    {S_HWR|S_TX,                 16'h0020}, // R5
    {S_HWR|S_TX,                 16'h0021}, // R9
    {S_COVR,                     16'h0020}, // R10
    {S_SUSP|S_HWR|S_TX,          16'h0001}, // R9 R4
    {S_COVR,                     16'h0000}, // R10
    {S_RXS,                      16'h0000}, // R6 rx disabled
    {S_RXS|S_RX,                 16'h0020}, // R6
    {S_HRD|S_RX,                 16'h0000}, // R6
    {S_RXS|S_RX|S_HRD,           16'h0020}, // R8 set wins
    {S_HRD,                      16'h0020}, // R6 rx disabled
    {S_STOP,                     16'h0000}, // R4
    {S_EFRM,                     16'h0024}, // R7
    {S_EPAR,                     16'h0026}, // R7
    {S_STOP,                     16'h0006}, // R4 errors kept
    {S_ERX,                      16'h0026}, // R7
    {S_CFRM,                     16'h0022}, // R10
    {S_CPAR|S_EPAR,              16'h0022}, // R10 set wins
    {S_CPAR,                     16'h0020}, // R10
    {S_STOP|S_START|S_RXS|S_RX,  16'h0000}, // R4 priority
    {S_START|S_HWR|S_TX,         16'h0060}, // R2 R3 R5
    {S_END|S_SHIFT|S_TX,         16'h0000}  // R3 R8
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_vec++;
    if (status_word !== exp || status_byte !== exp[7:0]) begin
      n_bad++;
      $display("FAIL %s: word=%h byte=%h expected word=%h byte=%h",
               req, status_word, status_byte, exp, exp[7:0]);
    end
  endtask

  task automatic apply(input logic [15:0] s);
    @(negedge clk) stim = s;
    @(posedge clk);
    #1 stim = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after reset", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:16]);
      check($sformatf("vector %0d R2 R11", i), VEC[i][15:0]);
    end

    // R12: no change before the edge, change right after it
    @(negedge clk) stim = S_START | S_EFRM;
    #1 check("R12 before edge", 16'h0000);
    @(posedge clk);
    #1 stim = '0;
    check("R12 after edge", 16'h0064);

    // R1: reset clears everything mid-run
    apply(S_HWR | S_TX);
    check("R9 setup", 16'h0065);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 check("R1 mid-run reset", 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule